// File: doc/BRIEF.md
# Operating Mode and Clock Controller

This block manages power for a small microcontroller-style core. It takes a per-cycle fast clock enable tick and a slow clock enable tick. It chooses which of them drives the system clock enable, and it reports the operating mode. It also drives the enables for both oscillators and for two slower peripheral clock taps derived from the fast clock. Software reaches the control bits through a single 8-bit register.

While the core runs, one control bit picks the undivided fast clock. When that bit is low, a 3-bit select field picks either the slow clock or the fast clock divided by 2 to 64. A move onto the slow clock waits until the slow oscillator reports stable, and a move back to the fast clock waits until the fast oscillator reports stable. A HALT strobe places the block in one of four low-power modes. Which one it enters depends on an idle-enable bit, a keep-clock bit and the watchdog and voltage-detector enable flags. A wake-up event returns the block to the running mode it left, and the core clock resumes only once the needed oscillator is stable again.

Top module: `opmode_clkctl`

## Requirements
- R1: After reset the mode output is NORMAL (code 0), the control register reads 0x01 with the slow-stable bit low (fast source selected, select field 000, idle-enable 0, keep-clock 0), and the fast oscillator enable is high.
- R2: With register bit 0 (fast select) at 1 in a running mode, `sys_ce` and `cpu_ce` follow `fast_tick` in the same cycle.
- R3: With bit 0 at 0 and select field bits 7:5 = s, where s is between 2 and 7, `sys_ce` pulses once per 2^(s-1) fast ticks.
- R4: With bit 0 at 0 and the select field at 000 or 001, the mode stays NORMAL, and `sys_ce` follows `fast_tick`, until `slow_stable` is seen high at a clock edge. SLOW (code 1) starts at the edge after that. Register bit 4 reads `slow_stable`.
- R5: In SLOW, `sys_ce` follows `slow_tick`, the fast oscillator enable is low and neither peripheral tap pulses.
- R6: While the fast oscillator runs, `tap_lo_ce` pulses once per 16 fast ticks and `tap_hi_ce` once per 64.
- R7: HALT in a running mode with idle-enable (bit 1) at 0 enters SLEEP0 (code 2) if `wdt_en` and `lvd_en` are both low, and SLEEP1 (code 3) otherwise.
- R8: HALT with idle-enable at 1 enters IDLE0 (code 4) when keep-clock (bit 2) is 0, and IDLE1 (code 5) when it is 1.
- R9: In every low-power mode and in the wake state, `cpu_ce` is low. `sys_ce` still runs from the active source only in IDLE1.
- R10: In SLEEP0 both oscillator enables are low. In SLEEP1, IDLE0 and IDLE1 the slow oscillator enable is high. The fast oscillator enable is low in SLEEP0, SLEEP1 and IDLE0.
- R11: A wake-up event in a low-power mode moves to the wake state (code 6). The block returns to the running mode it left at the first edge at which that mode's oscillator reports stable.
- R12: Register writes are ignored in the low-power modes and in the wake state.
- R13: A change from the slow clock back to the fast clock completes only after `fast_stable` is seen high. Until then the mode stays SLOW and the fast oscillator enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Fast clock enable tick |
| slow_tick | input | 1 | Slow clock enable tick |
| fast_stable | input | 1 | Fast oscillator reports stable |
| slow_stable | input | 1 | Slow oscillator reports stable |
| halt | input | 1 | HALT strobe from the core |
| wake | input | 1 | Wake-up event |
| wdt_en | input | 1 | Watchdog enabled flag |
| lvd_en | input | 1 | Voltage detector enabled flag |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| mode | output | 3 | Current operating mode code |
| sys_ce | output | 1 | System clock enable |
| cpu_ce | output | 1 | Core clock enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| slow_osc_en | output | 1 | Slow oscillator enable |
| tap_lo_ce | output | 1 | Fast clock divided by 16 tap |
| tap_hi_ce | output | 1 | Fast clock divided by 64 tap |

## Verification
A wrong stored source flag shows up in the mode code and the oscillator enables in the cycle after the edge that stored it. It also breaks the tick count on `sys_ce` within one divider period. A wrong low-power state decode shows up at once as a bad mode code, a gated enable that should run, or a core enable that fires during a halt. A control register that takes a write while halted gives itself away on the read port in the next cycle, and again by the running mode it returns to after the wake-up.

// File: rtl/opm_pkg.sv
// Package: shared types and codes for the operating mode controller.
// Assumes an 8-bit control register with a 3-bit source select field.
package opm_pkg;

    localparam int REG_W = 8;
    localparam int SEL_W = 3;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd0;
    localparam logic [MODE_W-1:0] MODE_SLOW   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SLEEP0 = 3'd2;
    localparam logic [MODE_W-1:0] MODE_SLEEP1 = 3'd3;
    localparam logic [MODE_W-1:0] MODE_IDLE0  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_IDLE1  = 3'd5;
    localparam logic [MODE_W-1:0] MODE_WAKE   = 3'd6;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP0,
        ST_SLEEP1,
        ST_IDLE0,
        ST_IDLE1,
        ST_WAKE
    } opm_state_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             keep_clk;
        logic             idle_en;
        logic             hl_sel;
    } opm_ctrl_t;

endpackage

// File: rtl/opm_regs.sv
// Control register: holds the source select, idle-enable, keep-clock and
// fast-select bits. Writes land only while the FSM allows them.
// Read layout: [7:5] select, [4] slow stable, [3] zero, [2] keep, [1] idle, [0] fast.
module opm_regs
    import opm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_allow,
    input  logic [REG_W-1:0] wdata,
    input  logic             slow_stable,
    output opm_ctrl_t        ctrl,
    output logic [REG_W-1:0] rdata
);

    // Capture permitted writes; reset selects the undivided fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '{sel: '0, keep_clk: 1'b0, idle_en: 1'b0, hl_sel: 1'b1};
        end else if (wr && wr_allow) begin
            ctrl.sel      <= wdata[7:5];
            ctrl.keep_clk <= wdata[2];
            ctrl.idle_en  <= wdata[1];
            ctrl.hl_sel   <= wdata[0];
        end
    end

    // Assemble the read view including the live stability status.
    always_comb begin
        rdata = {ctrl.sel, slow_stable, 1'b0, ctrl.keep_clk, ctrl.idle_en, ctrl.hl_sel};
    end

endmodule

// File: rtl/opm_divider.sv
// Fast clock divider: a free counter of fast ticks yields the divided
// system tick and the two peripheral taps. Counts only while 'run' is high.
module opm_divider
    import opm_pkg::*;
#(
    parameter int TAP_LO_LOG = 4,
    parameter int TAP_HI_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fast_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             div_tick,
    output logic             tap_lo,
    output logic             tap_hi
);

    localparam int CNT_W = TAP_HI_LOG;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic [SEL_W-1:0] expo;
    logic             tick;

    assign tick = run && fast_tick;

    // Advance the tick counter on every live fast tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Derive the low-bit mask for the selected division ratio.
    always_comb begin
        expo = sel - 1'b1;
        mask = ({{(CNT_W-1){1'b0}}, 1'b1} << expo) - 1'b1;
    end

    // Fire the divided tick and taps when their counter bits are all ones.
    always_comb begin
        div_tick = tick && ((cnt & mask) == mask);
        tap_lo   = tick && (&cnt[TAP_LO_LOG-1:0]);
        tap_hi   = tick && (&cnt[TAP_HI_LOG-1:0]);
    end

endmodule

// File: rtl/opm_fsm.sv
// Mode sequencer: tracks the running source (fast or slow), performs
// stability-gated source changes, and walks HALT / wake-up transitions.
module opm_fsm
    import opm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  opm_ctrl_t  ctrl,
    input  logic       halt,
    input  logic       wake,
    input  logic       wdt_en,
    input  logic       lvd_en,
    input  logic       fast_stable,
    input  logic       slow_stable,
    output opm_state_t state,
    output logic       cur_slow,
    output logic       want_slow
);

    opm_state_t halt_target;
    logic       ready;

    // Decode the requested source from the control bits.
    always_comb begin
        want_slow = !ctrl.hl_sel && (ctrl.sel[SEL_W-1:1] == '0);
    end

    // Pick the low-power mode a HALT would enter.
    always_comb begin
        if (ctrl.idle_en) begin
            halt_target = ctrl.keep_clk ? ST_IDLE1 : ST_IDLE0;
        end else begin
            halt_target = (wdt_en || lvd_en) ? ST_SLEEP1 : ST_SLEEP0;
        end
    end

    // The oscillator needed by the running source is stable.
    always_comb begin
        ready = cur_slow ? slow_stable : fast_stable;
    end

    // State and running-source register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            cur_slow <= 1'b0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (halt) begin
                        state <= halt_target;
                    end else if (want_slow && !cur_slow && slow_stable) begin
                        cur_slow <= 1'b1;
                    end else if (!want_slow && cur_slow && fast_stable) begin
                        cur_slow <= 1'b0;
                    end
                end
                ST_SLEEP0, ST_SLEEP1, ST_IDLE0, ST_IDLE1: begin
                    if (wake) begin
                        state <= ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (ready) begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

endmodule

// File: rtl/opmode_clkctl.sv
// Top: operating mode and clock controller. Combines the control register,
// fast divider and mode sequencer, and produces the clock enables,
// oscillator enables and the mode code. Ticks are single-cycle enables.
module opmode_clkctl
    import opm_pkg::*;
#(
    parameter int TAP_LO_LOG = 4,
    parameter int TAP_HI_LOG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              fast_stable,
    input  logic              slow_stable,
    input  logic              halt,
    input  logic              wake,
    input  logic              wdt_en,
    input  logic              lvd_en,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [MODE_W-1:0] mode,
    output logic              sys_ce,
    output logic              cpu_ce,
    output logic              fast_osc_en,
    output logic              slow_osc_en,
    output logic              tap_lo_ce,
    output logic              tap_hi_ce
);

    opm_ctrl_t  ctrl;
    opm_state_t state;
    logic       cur_slow;
    logic       want_slow;
    logic       div_tick;
    logic       src_tick;
    logic       fast_alive;

    opm_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .wr_allow    (state == ST_RUN),
        .wdata       (reg_wdata),
        .slow_stable (slow_stable),
        .ctrl        (ctrl),
        .rdata       (reg_rdata)
    );

    opm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .halt        (halt),
        .wake        (wake),
        .wdt_en      (wdt_en),
        .lvd_en      (lvd_en),
        .fast_stable (fast_stable),
        .slow_stable (slow_stable),
        .state       (state),
        .cur_slow    (cur_slow),
        .want_slow   (want_slow)
    );

    opm_divider #(
        .TAP_LO_LOG (TAP_LO_LOG),
        .TAP_HI_LOG (TAP_HI_LOG)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (fast_alive),
        .fast_tick (fast_tick),
        .sel       (ctrl.sel),
        .div_tick  (div_tick),
        .tap_lo    (tap_lo_ce),
        .tap_hi    (tap_hi_ce)
    );

    // Fast oscillator runs in run/IDLE1/wake unless the slow clock is the settled choice.
    always_comb begin
        fast_alive = ((state == ST_RUN) || (state == ST_IDLE1) || (state == ST_WAKE))
                     && (!cur_slow || !want_slow);
        fast_osc_en = fast_alive;
        slow_osc_en = (state != ST_SLEEP0);
    end

    // Select the tick of the source currently driving the system.
    always_comb begin
        if (cur_slow) begin
            src_tick = slow_tick;
        end else if (ctrl.hl_sel || want_slow) begin
            src_tick = fast_tick;
        end else begin
            src_tick = div_tick;
        end
    end

    // Gate the system and core enables by state.
    always_comb begin
        sys_ce = ((state == ST_RUN) || (state == ST_IDLE1)) && src_tick;
        cpu_ce = (state == ST_RUN) && src_tick;
    end

    // Map the internal state to the reported mode code.
    always_comb begin
        unique case (state)
            ST_RUN:    mode = cur_slow ? MODE_SLOW : MODE_NORMAL;
            ST_SLEEP0: mode = MODE_SLEEP0;
            ST_SLEEP1: mode = MODE_SLEEP1;
            ST_IDLE0:  mode = MODE_IDLE0;
            ST_IDLE1:  mode = MODE_IDLE1;
            default:   mode = MODE_WAKE;
        endcase
    end

endmodule

// File: rtl/opmode_clkctl_chk.sv
// Checker: temporal properties of the mode controller, observed at its ports.
module opmode_clkctl_chk
    import opm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              fast_stable,
    input logic              slow_stable,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [MODE_W-1:0] mode,
    input logic              sys_ce,
    input logic              cpu_ce,
    input logic              fast_osc_en,
    input logic              slow_osc_en,
    input logic              tap_lo_ce,
    input logic              tap_hi_ce
);

    logic past_ok;
    logic low_power;

    // Marks that at least one clock edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign low_power = (mode != MODE_NORMAL) && (mode != MODE_SLOW);

    a_r10_sleep0_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP0) |-> (!fast_osc_en && !slow_osc_en && !sys_ce));

    a_r10_sleep1_slow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP1) |-> (!fast_osc_en && slow_osc_en));

    a_r9_cpu_held: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> !cpu_ce);

    a_r9_sys_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && (mode != MODE_IDLE1)) |-> !sys_ce);

    a_r5_taps_need_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_osc_en |-> (!tap_lo_ce && !tap_hi_ce));

    a_r4_slow_needs_stable: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((mode == MODE_SLOW) && ($past(mode) != MODE_SLOW)) |-> $past(slow_stable));

    a_r13_fast_needs_stable: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((mode == MODE_NORMAL) && ($past(mode) != MODE_NORMAL)) |-> $past(fast_stable));

    a_r12_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> $stable(reg_rdata & 8'hE7));

    a_r7_halt_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !low_power) |=> ((mode >= MODE_SLEEP0) && (mode <= MODE_IDLE1)));

endmodule

bind opmode_clkctl opmode_clkctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .fast_stable (fast_stable),
    .slow_stable (slow_stable),
    .reg_rdata   (reg_rdata),
    .mode        (mode),
    .sys_ce      (sys_ce),
    .cpu_ce      (cpu_ce),
    .fast_osc_en (fast_osc_en),
    .slow_osc_en (slow_osc_en),
    .tap_lo_ce   (tap_lo_ce),
    .tap_hi_ce   (tap_hi_ce)
);

// File: tb/opmode_clkctl_tb.sv
// Scoreboard bench: the driver queues expected values, the monitor samples
// the named output at the falling edge and compares.
module opmode_clkctl_tb;

    localparam int SIG_NONE  = 0;
    localparam int SIG_MODE  = 1;
    localparam int SIG_SYS   = 2;
    localparam int SIG_CPU   = 3;
    localparam int SIG_FOSC  = 4;
    localparam int SIG_SOSC  = 5;
    localparam int SIG_RDATA = 6;

    typedef struct {
        string tag;
        int    sig;
        int    exp;
        int    act;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_tick = 1'b1;
    logic       slow_tick = 1'b0;
    logic       fast_stable = 1'b1;
    logic       slow_stable = 1'b0;
    logic       halt = 1'b0;
    logic       wake = 1'b0;
    logic       wdt_en = 1'b0;
    logic       lvd_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] mode;
    logic       sys_ce, cpu_ce, fast_osc_en, slow_osc_en, tap_lo_ce, tap_hi_ce;

    sb_item_t sb_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opmode_clkctl u_dut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .fast_stable(fast_stable), .slow_stable(slow_stable), .halt(halt), .wake(wake),
        .wdt_en(wdt_en), .lvd_en(lvd_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode(mode), .sys_ce(sys_ce), .cpu_ce(cpu_ce),
        .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en),
        .tap_lo_ce(tap_lo_ce), .tap_hi_ce(tap_hi_ce)
    );

    // Driver side: queue an expectation on a design output.
    task automatic expect_sig(input string tag, input int sig, input int exp);
        sb_item_t it;
        it.tag = tag; it.sig = sig; it.exp = exp; it.act = 0;
        sb_q.push_back(it);
    endtask

    // Driver side: queue a bench-measured value (counts) for comparison.
    task automatic expect_val(input string tag, input int act, input int exp);
        sb_item_t it;
        it.tag = tag; it.sig = SIG_NONE; it.exp = exp; it.act = act;
        sb_q.push_back(it);
    endtask

    // Monitor: sample outputs just after the falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                int got;
                it = sb_q.pop_front();
                case (it.sig)
                    SIG_MODE:  got = int'(mode);
                    SIG_SYS:   got = int'(sys_ce);
                    SIG_CPU:   got = int'(cpu_ce);
                    SIG_FOSC:  got = int'(fast_osc_en);
                    SIG_SOSC:  got = int'(slow_osc_en);
                    SIG_RDATA: got = int'(reg_rdata);
                    default:   got = it.act;
                endcase
                n_checks++;
                if (got != it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %0d expected %0d", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] v);
        cyc(1);
        reg_wr = 1'b1; reg_wdata = v;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_halt();
        cyc(1);
        halt = 1'b1;
        cyc(1);
        halt = 1'b0;
    endtask

    task automatic pulse_wake();
        cyc(1);
        wake = 1'b1;
        cyc(1);
        wake = 1'b0;
    endtask

    task automatic count_sys(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (sys_ce) c++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int c, lo, hi;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        expect_sig("R1 reset mode", SIG_MODE, 0);
        expect_sig("R1 reset reg", SIG_RDATA, 8'h01);
        expect_sig("R1 fast osc on", SIG_FOSC, 1);

        // R2: fast source follows fast_tick
        cyc(1); fast_tick = 1'b0;
        @(negedge clk);
        expect_sig("R2 sys low", SIG_SYS, 0);
        expect_sig("R2 cpu low", SIG_CPU, 0);
        cyc(1); fast_tick = 1'b1;
        @(negedge clk);
        expect_sig("R2 sys high", SIG_SYS, 1);
        expect_sig("R2 cpu high", SIG_CPU, 1);

        // R6: tap rates over 128 fast ticks
        lo = 0; hi = 0;
        repeat (128) begin
            @(negedge clk);
            if (tap_lo_ce) lo++;
            if (tap_hi_ce) hi++;
        end
        expect_val("R6 tap16 count", lo, 8);
        expect_val("R6 tap64 count", hi, 2);

        // R3: divided sources
        wr_reg(8'h60);
        count_sys(64, c);
        expect_val("R3 div4 count", c, 16);
        wr_reg(8'hE0);
        count_sys(128, c);
        expect_val("R3 div64 count", c, 2);
        expect_sig("R3 mode normal", SIG_MODE, 0);

        // R4: slow request waits for stability
        wr_reg(8'h00);
        cyc(4);
        @(negedge clk);
        expect_sig("R4 still normal", SIG_MODE, 0);
        expect_sig("R4 on fast tick", SIG_SYS, 1);
        expect_sig("R4 status low", SIG_RDATA, 8'h00);
        cyc(1); slow_stable = 1'b1;
        @(negedge clk);
        expect_sig("R4 not yet slow", SIG_MODE, 0);
        expect_sig("R4 status high", SIG_RDATA, 8'h10);
        @(negedge clk);
        expect_sig("R4 slow entered", SIG_MODE, 1);

        // R5: slow mode behaviour
        cyc(1); slow_tick = 1'b0;
        @(negedge clk);
        expect_sig("R5 sys follows slow low", SIG_SYS, 0);
        expect_sig("R5 fast osc off", SIG_FOSC, 0);
        cyc(1); slow_tick = 1'b1;
        @(negedge clk);
        expect_sig("R5 sys follows slow high", SIG_SYS, 1);
        lo = 0; hi = 0;
        repeat (64) begin
            @(negedge clk);
            if (tap_lo_ce) lo++;
            if (tap_hi_ce) hi++;
        end
        expect_val("R5 taps silent", lo + hi, 0);

        // R7 / R10: SLEEP0
        pulse_halt();
        slow_stable = 1'b0;
        @(negedge clk);
        expect_sig("R7 sleep0", SIG_MODE, 2);
        expect_sig("R9 sys gated sleep0", SIG_SYS, 0);
        expect_sig("R9 cpu held sleep0", SIG_CPU, 0);
        expect_sig("R10 slow osc off", SIG_SOSC, 0);
        expect_sig("R10 fast osc off", SIG_FOSC, 0);

        // R12: write ignored while asleep
        wr_reg(8'h01);
        @(negedge clk);
        expect_sig("R12 reg unchanged", SIG_RDATA, 8'h00);

        // R11: wake waits for slow oscillator
        pulse_wake();
        @(negedge clk);
        expect_sig("R11 wake state", SIG_MODE, 6);
        expect_sig("R11 cpu held", SIG_CPU, 0);
        expect_sig("R11 slow osc on", SIG_SOSC, 1);
        cyc(1); slow_stable = 1'b1;
        @(negedge clk);
        expect_sig("R11 still waking", SIG_MODE, 6);
        @(negedge clk);
        expect_sig("R11 back to slow", SIG_MODE, 1);
        expect_sig("R11 cpu resumes", SIG_CPU, 1);

        // R7 / R10: SLEEP1
        wdt_en = 1'b1;
        pulse_halt();
        @(negedge clk);
        expect_sig("R7 sleep1", SIG_MODE, 3);
        expect_sig("R10 sleep1 slow on", SIG_SOSC, 1);
        expect_sig("R10 sleep1 fast off", SIG_FOSC, 0);
        pulse_wake();
        cyc(1);
        wdt_en = 1'b0;
        @(negedge clk);
        expect_sig("R11 sleep1 return slow", SIG_MODE, 1);

        // R8 / R9: IDLE0
        wr_reg(8'h02);
        pulse_halt();
        @(negedge clk);
        expect_sig("R8 idle0", SIG_MODE, 4);
        expect_sig("R9 idle0 sys gated", SIG_SYS, 0);
        expect_sig("R10 idle0 slow on", SIG_SOSC, 1);
        pulse_wake();
        cyc(1);
        @(negedge clk);
        expect_sig("R11 idle0 return", SIG_MODE, 1);

        // R8 / R9: IDLE1
        wr_reg(8'h06);
        pulse_halt();
        @(negedge clk);
        expect_sig("R8 idle1", SIG_MODE, 5);
        expect_sig("R9 idle1 sys runs", SIG_SYS, 1);
        expect_sig("R9 idle1 cpu held", SIG_CPU, 0);
        pulse_wake();
        cyc(1);
        @(negedge clk);
        expect_sig("R11 idle1 return", SIG_MODE, 1);

        // R13: back to fast waits for fast oscillator
        fast_stable = 1'b0;
        wr_reg(8'h01);
        @(negedge clk);
        expect_sig("R13 still slow", SIG_MODE, 1);
        expect_sig("R13 fast osc starting", SIG_FOSC, 1);
        cyc(1); fast_stable = 1'b1;
        @(negedge clk);
        expect_sig("R13 not yet normal", SIG_MODE, 1);
        @(negedge clk);
        expect_sig("R13 normal", SIG_MODE, 0);

        // R7 / R11: SLEEP1 via voltage detector, wake needs fast oscillator
        lvd_en = 1'b1;
        pulse_halt();
        fast_stable = 1'b0;
        @(negedge clk);
        expect_sig("R7 sleep1 via lvd", SIG_MODE, 3);
        pulse_wake();
        @(negedge clk);
        expect_sig("R11 wake fast", SIG_MODE, 6);
        expect_sig("R11 fast osc on in wake", SIG_FOSC, 1);
        expect_sig("R11 cpu held fast", SIG_CPU, 0);
        cyc(1); fast_stable = 1'b1; lvd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_sig("R11 back to normal", SIG_MODE, 0);
        expect_sig("R11 cpu resumes fast", SIG_CPU, 1);

        cyc(2);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule